// File: doc/BRIEF.md
# Peak-to-Peak Amplitude Threshold Detector

This block watches a stream of unsigned ADC codes that sample an AC waveform centred on mid-scale. It keeps a running largest and a running smallest code. When both extremes have stopped moving, it takes their difference as the peak-to-peak swing and compares that swing with a threshold supplied by the surrounding logic. It then reports the outcome and begins a new measurement from mid-scale. Because the minimum is subtracted from the maximum before the comparison, a slow drift of the zero-signal offset does not move the decision.

Settling is judged with two sticky flags, one for each extreme. Both flags are set at the start of a measurement. Each flag drops the first time an accepted sample fails to replace its extreme. The measurement closes on the accepted sample that leaves both flags clear, and that sample's own update still counts. The comparison is strict by default; a parameter selects an inclusive comparison instead.

Top module: `pk_p2p_detector`

## Requirements
- R1: After reset, `res_valid`, `res_above` and `res_p2p` are 0, and both trackers hold mid-scale, which is 2^(SAMPLE_W-1) (512 for the default width of 10 bits).
- R2: An accepted sample replaces the maximum tracker only if it is strictly greater than it. A sample equal to the maximum is a failed replacement.
- R3: An accepted sample replaces the minimum tracker only if it is strictly less than it. A sample equal to the minimum is a failed replacement.
- R4: Each settle flag is set at the start of a measurement. It is cleared by the first accepted sample that fails to replace its extreme, and it stays clear even if a later sample does replace that extreme. The measurement completes on the accepted sample after whose update both flags are clear.
- R5: On the clock edge that accepts the completing sample, `res_p2p` becomes maximum minus minimum. Both values include that sample's update, and the result is visible in the following cycle.
- R6: With the default strict mode, `res_above` is 1 when the peak-to-peak value is greater than `thresh` as sampled on the completing cycle, and 0 when it is equal or less.
- R7: `res_valid` is high for exactly one cycle per completed measurement. `res_above` and `res_p2p` hold their values until the next result.
- R8: In the same edge that produces a result, both trackers return to mid-scale and both flags are set again, so the next measurement does not depend on the previous samples.
- R9: A cycle with `smp_valid` low changes no tracker, no flag and no output, whatever `smp_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; at most one sample per cycle |
| smp_data | input | SAMPLE_W | Unsigned ADC code |
| thresh | input | SAMPLE_W | Peak-to-peak decision threshold |
| res_valid | output | 1 | One-cycle pulse per completed measurement |
| res_above | output | 1 | Swing exceeds the threshold; held between results |
| res_p2p | output | SAMPLE_W | Measured maximum minus minimum; held between results |

## Verification
A single accepted sample can both move one extreme and close the measurement, and in that same edge the trackers are reseeded while the result is registered. The bench provokes this with the sequence 600, 700, 400 from reset. The last sample lowers the minimum and clears the maximum flag, which was the only flag still set. The bench expects a peak-to-peak of 300, not the 188 that a pre-update minimum would give. A following sample of 512 must then complete at once with a swing of 0, which shows that the reseed took effect in that same edge. Sticky flag behaviour is separated from re-arming flag behaviour by the sequence 500, 700, which must complete with a swing of 200.

// File: rtl/pk_pkg.sv
package pk_pkg;

   // Comparison applied between the measured swing and the threshold.
   typedef enum logic {
      CMP_STRICT    = 1'b0,   // above when swing >  threshold
      CMP_INCLUSIVE = 1'b1    // above when swing >= threshold
   } pk_cmp_e;

   // Tracker orientation.
   typedef enum logic {
      TRK_MAX = 1'b0,
      TRK_MIN = 1'b1
   } pk_trk_e;

endpackage

// File: rtl/pk_extreme_tracker.sv
module pk_extreme_tracker #(
   parameter int             SAMPLE_W = 10,
   parameter pk_pkg::pk_trk_e KIND    = pk_pkg::TRK_MAX
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd,        // accepted sample this cycle
   input  logic                reseed,     // measurement closes this cycle
   input  logic [SAMPLE_W-1:0] sample,
   output logic [SAMPLE_W-1:0] value_q,
   output logic [SAMPLE_W-1:0] value_nxt,  // value after this cycle's update
   output logic                flag_q,
   output logic                flag_nxt    // settle flag after this cycle's update
);

   localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

   logic beats;

   generate
      if (KIND == pk_pkg::TRK_MAX) begin : g_max
         assign beats = (sample > value_q);
      end else begin : g_min
         assign beats = (sample < value_q);
      end
   endgenerate

   assign value_nxt = (upd && beats) ? sample : value_q;
   assign flag_nxt  = flag_q && (!upd || beats);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value_q <= MID;
         flag_q  <= 1'b1;
      end else if (reseed) begin
         value_q <= MID;
         flag_q  <= 1'b1;
      end else begin
         value_q <= value_nxt;
         flag_q  <= flag_nxt;
      end
   end

endmodule

// File: rtl/pk_decide.sv
module pk_decide #(
   parameter int              SAMPLE_W = 10,
   parameter pk_pkg::pk_cmp_e CMP_MODE = pk_pkg::CMP_STRICT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  logic [SAMPLE_W-1:0] hi,
   input  logic [SAMPLE_W-1:0] lo,
   input  logic [SAMPLE_W-1:0] thresh,
   output logic                res_valid,
   output logic                res_above,
   output logic [SAMPLE_W-1:0] res_p2p
);

   logic [SAMPLE_W-1:0] swing;
   logic                over;

   // hi is never below mid-scale and lo never above it, so no borrow.
   assign swing = hi - lo;

   generate
      if (CMP_MODE == pk_pkg::CMP_INCLUSIVE) begin : g_incl
         assign over = (swing >= thresh);
      end else begin : g_strict
         assign over = (swing > thresh);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_above <= 1'b0;
         res_p2p   <= '0;
      end else begin
         res_valid <= fire;
         if (fire) begin
            res_above <= over;
            res_p2p   <= swing;
         end
      end
   end

endmodule

// File: rtl/pk_p2p_detector.sv
module pk_p2p_detector #(
   parameter int              SAMPLE_W = 10,
   parameter pk_pkg::pk_cmp_e CMP_MODE = pk_pkg::CMP_STRICT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic [SAMPLE_W-1:0] thresh,
   output logic                res_valid,
   output logic                res_above,
   output logic [SAMPLE_W-1:0] res_p2p
);

   localparam int NTRK = 2;

   generate
      if (SAMPLE_W < 2 || SAMPLE_W > 32) begin : g_bad_width
         $error("pk_p2p_detector: SAMPLE_W must lie in 2..32");
      end
   endgenerate

   logic [SAMPLE_W-1:0] trk_val  [NTRK];
   logic [SAMPLE_W-1:0] trk_nxt  [NTRK];
   logic [NTRK-1:0]     trk_flag;
   logic [NTRK-1:0]     trk_fnxt;
   logic                done;

   // Index 0 follows the maximum, index 1 the minimum.
   generate
      for (genvar gi = 0; gi < NTRK; gi++) begin : g_trk
         pk_extreme_tracker #(
            .SAMPLE_W (SAMPLE_W),
            .KIND     ((gi == 0) ? pk_pkg::TRK_MAX : pk_pkg::TRK_MIN)
         ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd       (smp_valid),
            .reseed    (done),
            .sample    (smp_data),
            .value_q   (trk_val[gi]),
            .value_nxt (trk_nxt[gi]),
            .flag_q    (trk_flag[gi]),
            .flag_nxt  (trk_fnxt[gi])
         );
      end
   endgenerate

   assign done = smp_valid && (trk_fnxt == '0);

   pk_decide #(
      .SAMPLE_W (SAMPLE_W),
      .CMP_MODE (CMP_MODE)
   ) u_decide (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (done),
      .hi        (trk_nxt[0]),
      .lo        (trk_nxt[1]),
      .thresh    (thresh),
      .res_valid (res_valid),
      .res_above (res_above),
      .res_p2p   (res_p2p)
   );

   // Named views of tracker state for the bound checker.
   logic [SAMPLE_W-1:0] max_q;
   logic [SAMPLE_W-1:0] min_q;
   logic                fmax_q;
   logic                fmin_q;

   assign max_q  = trk_val[0];
   assign min_q  = trk_val[1];
   assign fmax_q = trk_flag[0];
   assign fmin_q = trk_flag[1];

endmodule

// File: rtl/pk_p2p_detector_chk.sv
module pk_p2p_detector_chk #(
   parameter int              SAMPLE_W = 10,
   parameter pk_pkg::pk_cmp_e CMP_MODE = pk_pkg::CMP_STRICT
) (
   input logic                clk,
   input logic                rst_n,
   input logic                smp_valid,
   input logic [SAMPLE_W-1:0] smp_data,
   input logic [SAMPLE_W-1:0] thresh,
   input logic                res_valid,
   input logic                res_above,
   input logic [SAMPLE_W-1:0] res_p2p,
   input logic [SAMPLE_W-1:0] max_q,
   input logic [SAMPLE_W-1:0] min_q,
   input logic                fmax_q,
   input logic                fmin_q
);

   localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);
   localparam bit INCL = (CMP_MODE == pk_pkg::CMP_INCLUSIVE);

   // R2: the maximum tracker never falls below mid-scale
   a_r2_max_floor: assert property (@(posedge clk) disable iff (!rst_n)
      max_q >= MID);

   // R3: the minimum tracker never rises above mid-scale
   a_r3_min_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      min_q <= MID);

   // R2: the maximum only moves to a larger accepted sample
   a_r2_max_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_valid && max_q != $past(max_q)) |->
         ($past(smp_valid) && max_q == $past(smp_data) && max_q > $past(max_q)));

   // R4: a cleared flag stays clear until a result is issued
   a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!fmax_q && !res_valid) |=> (!fmax_q || res_valid));

   // R4: a result can only follow an accepted sample
   a_r4_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(smp_valid));

   // R6: the above flag agrees with the reported swing and the sampled threshold
   a_r6_decision: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_above == (INCL ? (res_p2p >= $past(thresh))
                                        : (res_p2p >  $past(thresh)))));

   // R7: outputs hold between results
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> ($stable(res_above) && $stable(res_p2p)));

   // R8: the trackers are reseeded together with each result
   a_r8_reseed: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (max_q == MID && min_q == MID && fmax_q && fmin_q));

   // R9: no accepted sample, no result in the next cycle
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> !res_valid);

   // R9: trackers are frozen without a sample
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> ($stable(max_q) && $stable(min_q)));

endmodule

bind pk_p2p_detector pk_p2p_detector_chk #(
   .SAMPLE_W (SAMPLE_W),
   .CMP_MODE (CMP_MODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .smp_data  (smp_data),
   .thresh    (thresh),
   .res_valid (res_valid),
   .res_above (res_above),
   .res_p2p   (res_p2p),
   .max_q     (max_q),
   .min_q     (min_q),
   .fmax_q    (fmax_q),
   .fmin_q    (fmin_q)
);

// File: tb/pk_p2p_detector_tb.sv
module pk_p2p_detector_tb;

   localparam int  W        = 10;
   localparam time CLK_HALF = 5ns;
   localparam time CLK_PER  = 2 * CLK_HALF;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         smp_valid = 1'b0;
   logic [W-1:0] smp_data = '0;
   logic [W-1:0] thresh = '0;
   logic         res_valid;
   logic         res_above;
   logic [W-1:0] res_p2p;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #CLK_HALF clk = ~clk;

   pk_p2p_detector #(.SAMPLE_W(W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .thresh    (thresh),
      .res_valid (res_valid),
      .res_above (res_above),
      .res_p2p   (res_p2p)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Drive one sample for one cycle; outputs are sampled at the next falling edge.
   task automatic send(input int s);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = W'(s);
      @(negedge clk);
      smp_valid = 1'b0;
      smp_data  = '0;
   endtask

   // Send a sequence; every sample except the last must give no result,
   // the last must give the expected result.
   task automatic measure(input string req, input int seq[], input int exp_p2p, input bit exp_above);
      foreach (seq[i]) begin
         send(seq[i]);
         if (i < seq.size() - 1)
            check(req, "no early result", int'(res_valid), 0);
      end
      check(req, "result valid", int'(res_valid), 1);
      check(req, "peak-to-peak", int'(res_p2p), exp_p2p);
      check(req, "above flag", int'(res_above), int'(exp_above));
      @(negedge clk);
      check("R7", "pulse lasts one cycle", int'(res_valid), 0);
   endtask

   task automatic t_reset();
      check("R1", "res_valid after reset", int'(res_valid), 0);
      check("R1", "res_above after reset", int'(res_above), 0);
      check("R1", "res_p2p after reset", int'(res_p2p), 0);
   endtask

   task automatic t_update_and_close();
      // 600 raises max, clears min flag; 700 raises max; 400 lowers min and
      // clears the max flag in the same cycle it closes: 700-400.
      thresh = W'(250);
      measure("R5", '{600, 700, 400}, 300, 1'b1);
   endtask

   task automatic t_idle();
      @(negedge clk);
      smp_data = W'(1023);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         check("R9", "no result while idle", int'(res_valid), 0);
      end
      check("R7", "above held", int'(res_above), 1);
      check("R7", "p2p held", int'(res_p2p), 300);
      smp_data = '0;
      // The junk data must not have moved the trackers: 512 closes at once.
      measure("R9", '{512}, 0, 1'b0);
   endtask

   task automatic t_reseed();
      // Mid-scale after a result: a lone mid-scale sample fails both extremes.
      measure("R8", '{512}, 0, 1'b0);
   endtask

   task automatic t_threshold_edge();
      thresh = W'(100);
      measure("R6", '{562, 462}, 100, 1'b0);
      thresh = W'(99);
      measure("R6", '{562, 462}, 100, 1'b1);
   endtask

   task automatic t_equal_extremes();
      thresh = W'(0);
      measure("R2", '{600, 600}, 88, 1'b1);
      measure("R3", '{450, 450}, 62, 1'b1);
   endtask

   task automatic t_rising_run();
      thresh = W'(68);
      measure("R2", '{520, 540, 560, 580, 560}, 68, 1'b0);
   endtask

   task automatic t_sticky();
      // 500 clears the max flag; 700 still raises max but the flag stays
      // clear, and it clears the min flag: done with 700-500.
      thresh = W'(150);
      measure("R4", '{500, 700}, 200, 1'b1);
   endtask

   task automatic t_full_swing();
      thresh = W'(1022);
      measure("R3", '{1023, 0}, 1023, 1'b1);
      thresh = W'(1023);
      measure("R6", '{1023, 0}, 1023, 1'b0);
   endtask

   initial begin : watchdog
      #(CLK_PER * 50000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_update_and_close();
      t_idle();
      t_reseed();
      t_threshold_edge();
      t_equal_extremes();
      t_rising_run();
      t_sticky();
      t_full_swing();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule